// File: doc/BRIEF.md
# Debug Data Transfer Mailbox

This block holds two one-way 32-bit mailbox registers that carry data between a processor core and an external debugger. The inbound register is loaded by the debugger and read by the core. The outbound register is loaded by the core and read by the debugger. Each register has a full flag. The side that loads a register sets its flag, and the side that consumes the register clears it. Each side polls the flags to pace the exchange.

Core accesses arrive as coprocessor requests. Each request carries a four-field selector, a direction, a privilege flag and the user-lock control bit. The block claims a request only when the selector addresses the mailbox. Both directions share that one address: a write goes to the outbound register and a read comes from the inbound register. A user-mode access made while the lock bit is set is refused. The block then raises an undefined-instruction pulse in the same cycle and changes no state.

Top module: `dbg_xfer_mbox`

## Requirements
- R1: While reset is active, and in the cycle after reset is released, both full flags read 0 and both data outputs read 0.
- R2: Consider a claimed write request (core_req_i=1, core_wr_i=1). After the next clock edge, the outbound register holds core_wdata_i, dbg_rdata_o shows that value and tx_full_o is 1.
- R3: When dbg_wr_i is 1, the inbound register loads dbg_wdata_i at the next edge. From that edge, core_rdata_o shows the value and rx_full_o is 1.
- R4: During a claimed read request (core_wr_i=0), core_rdata_o shows the inbound register in the same cycle and core_ack_o is 1. After the edge, rx_full_o is 0.
- R5: A cycle with dbg_rd_i=1 clears tx_full_o at the next edge. dbg_rdata_o keeps its value.
- R6: A request is claimed only when op1=0, crn=0, crm=5 and op2=0. Any other selector gives core_ack_o=0 and core_undef_o=0, and no flag or register changes.
- R7: When core_priv_i=1, a request to the mailbox is accepted whatever the value of user_lock_i.
- R8: When core_priv_i=0 and user_lock_i=0, reads and writes to the mailbox are accepted.
- R9: When core_priv_i=0 and user_lock_i=1, a request to the mailbox drives core_undef_o=1 in the same cycle, with core_ack_o=0. No register and no flag changes.
- R10: When a set and a clear of the same full flag occur in one cycle, the flag ends at 1 and the data register takes the new value.
- R11: All 32 bits of both registers hold data, and both registers use the same bit layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_req_i | input | 1 | Core coprocessor request valid |
| core_wr_i | input | 1 | 1 = core write (to outbound), 0 = core read (from inbound) |
| core_priv_i | input | 1 | 1 = privileged mode |
| user_lock_i | input | 1 | User-access lock bit from the debug control register |
| core_op1_i | input | 3 | Selector field op1 |
| core_crn_i | input | 4 | Selector field crn |
| core_crm_i | input | 4 | Selector field crm |
| core_op2_i | input | 3 | Selector field op2 |
| core_wdata_i | input | 32 | Core write data |
| core_rdata_o | output | 32 | Inbound register contents |
| core_ack_o | output | 1 | Request claimed and permitted |
| core_undef_o | output | 1 | Undefined-instruction pulse for a refused access |
| dbg_wr_i | input | 1 | Debugger loads the inbound register |
| dbg_wdata_i | input | 32 | Debugger write data |
| dbg_rd_i | input | 1 | Debugger consumes the outbound register |
| dbg_rdata_o | output | 32 | Outbound register contents |
| rx_full_o | output | 1 | Inbound register full |
| tx_full_o | output | 1 | Outbound register full |

## Verification
core_ack_o, core_undef_o and core_rdata_o depend on the request only through combinational logic. They are therefore due in the same cycle as the request. Both full flags and dbg_rdata_o pass through one register and are due one edge later. Each vector drives its inputs on the falling edge and samples the combinational results 1 ns later, before the rising edge. It samples the registered results 1 ns after that rising edge. A refused access or a foreign selector is therefore observed on the flags and the data outputs before the next vector is driven.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  localparam int unsigned OP1_W = 3;
  localparam int unsigned CR_W  = 4;
  localparam int unsigned OP2_W = 3;

  localparam logic [OP1_W-1:0] MBOX_OP1 = 3'd0;
  localparam logic [CR_W-1:0]  MBOX_CRN = 4'd0;
  localparam logic [CR_W-1:0]  MBOX_CRM = 4'd5;
  localparam logic [OP2_W-1:0] MBOX_OP2 = 3'd0;

  typedef struct packed {
    logic [OP1_W-1:0] op1;
    logic [CR_W-1:0]  crn;
    logic [CR_W-1:0]  crm;
    logic [OP2_W-1:0] op2;
  } cp_sel_t;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_OK,
    ACC_TRAP
  } acc_res_e;
endpackage

// File: rtl/dbg_mbox_decode.sv
module dbg_mbox_decode
  import dbg_mbox_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    wr_i,
  input  logic    priv_i,
  input  logic    lock_i,
  input  cp_sel_t sel_i,
  output logic    ack_o,
  output logic    undef_o,
  output logic    core_wr_o,
  output logic    core_rd_o
);
  logic     hit;
  acc_res_e res;

  assign hit = (sel_i.op1 == MBOX_OP1) && (sel_i.crn == MBOX_CRN) &&
               (sel_i.crm == MBOX_CRM) && (sel_i.op2 == MBOX_OP2);

  always_comb begin
    res = ACC_NONE;
    if (req_i && hit) begin
      if (!priv_i && lock_i) res = ACC_TRAP;
      else                   res = ACC_OK;
    end
  end

  assign ack_o     = (res == ACC_OK);
  assign undef_o   = (res == ACC_TRAP);
  assign core_wr_o = ack_o && wr_i;
  assign core_rd_o = ack_o && !wr_i;

  // R9
  undef_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(undef_o && (core_wr_o || core_rd_o)));
  // R7
  priv_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_i |-> !undef_o);
endmodule

// File: rtl/dbg_mbox_slot.sv
module dbg_mbox_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (load_i) data_q <= data_i;
      // load beats take
      if (load_i)      full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  // R10
  load_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_o);
  // R4
  take_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !load_i) |=> !full_o);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));
endmodule

// File: rtl/dbg_xfer_mbox.sv
module dbg_xfer_mbox
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_req_i,
  input  logic              core_wr_i,
  input  logic              core_priv_i,
  input  logic              user_lock_i,
  input  logic [OP1_W-1:0]  core_op1_i,
  input  logic [CR_W-1:0]   core_crn_i,
  input  logic [CR_W-1:0]   core_crm_i,
  input  logic [OP2_W-1:0]  core_op2_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic [DATA_W-1:0] core_rdata_o,
  output logic              core_ack_o,
  output logic              core_undef_o,
  input  logic              dbg_wr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic              dbg_rd_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  output logic              rx_full_o,
  output logic              tx_full_o
);
  cp_sel_t sel;
  logic    core_wr_en, core_rd_en;

  assign sel = '{op1: core_op1_i, crn: core_crn_i, crm: core_crm_i, op2: core_op2_i};

  dbg_mbox_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (core_req_i),
    .wr_i      (core_wr_i),
    .priv_i    (core_priv_i),
    .lock_i    (user_lock_i),
    .sel_i     (sel),
    .ack_o     (core_ack_o),
    .undef_o   (core_undef_o),
    .core_wr_o (core_wr_en),
    .core_rd_o (core_rd_en)
  );

  // inbound: debugger loads, core takes
  dbg_mbox_slot #(.DATA_W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dbg_wr_i),
    .data_i (dbg_wdata_i),
    .take_i (core_rd_en),
    .data_o (core_rdata_o),
    .full_o (rx_full_o)
  );

  // outbound: core loads, debugger takes
  dbg_mbox_slot #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (core_wr_en),
    .data_i (core_wdata_i),
    .take_i (dbg_rd_i),
    .data_o (dbg_rdata_o),
    .full_o (tx_full_o)
  );

  // R9
  trap_keeps_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_undef_o |=> ($stable(dbg_rdata_o) && ($past(tx_full_o) || !tx_full_o)));
  // R6
  foreign_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_crm_i != MBOX_CRM) |-> (!core_ack_o && !core_undef_o));
  // R2
  core_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_ack_o && core_wr_i) |=> (tx_full_o && dbg_rdata_o == $past(core_wdata_i)));
endmodule

// File: tb/sim_dbg_xfer_mbox.sv
module sim_dbg_xfer_mbox;
  typedef struct packed {
    logic        req, wr, priv, lock;
    logic [3:0]  crm;
    logic        bad_op1;
    logic [31:0] cwd;
    logic        dw;
    logic [31:0] dwd;
    logic        dr;
    logic        e_ack, e_undef;
    logic [31:0] e_crd;
    logic        e_rxf, e_txf;
    logic [31:0] e_drd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R3 debugger loads inbound
    '{1'b0,1'b0,1'b0,1'b0,4'd5,1'b0,32'h0,1'b1,32'hA5A5_0001,1'b0, 1'b0,1'b0,32'h0,         1'b1,1'b0,32'h0,         4'd3},
    // R7 R4 privileged read with lock set
    '{1'b1,1'b0,1'b1,1'b1,4'd5,1'b0,32'h0,1'b0,32'h0,1'b0,          1'b1,1'b0,32'hA5A5_0001,1'b0,1'b0,32'h0,         4'd4},
    // R2 privileged write with lock set
    '{1'b1,1'b1,1'b1,1'b1,4'd5,1'b0,32'hDEAD_BEEF,1'b0,32'h0,1'b0,  1'b1,1'b0,32'hA5A5_0001,1'b0,1'b1,32'hDEAD_BEEF,4'd2},
    // R5 debugger consumes outbound
    '{1'b0,1'b0,1'b0,1'b0,4'd5,1'b0,32'h0,1'b0,32'h0,1'b1,          1'b0,1'b0,32'hA5A5_0001,1'b0,1'b0,32'hDEAD_BEEF,4'd5},
    // R8 user write, unlocked
    '{1'b1,1'b1,1'b0,1'b0,4'd5,1'b0,32'h1234_5678,1'b0,32'h0,1'b0,  1'b1,1'b0,32'hA5A5_0001,1'b0,1'b1,32'h1234_5678,4'd8},
    // R9 user write, locked
    '{1'b1,1'b1,1'b0,1'b1,4'd5,1'b0,32'hFFFF_FFFF,1'b0,32'h0,1'b0,  1'b0,1'b1,32'hA5A5_0001,1'b0,1'b1,32'h1234_5678,4'd9},
    // R3 second debugger load
    '{1'b0,1'b0,1'b0,1'b0,4'd5,1'b0,32'h0,1'b1,32'h0F0F_0F0F,1'b0,  1'b0,1'b0,32'hA5A5_0001,1'b1,1'b1,32'h1234_5678,4'd3},
    // R9 user read, locked: flag kept
    '{1'b1,1'b0,1'b0,1'b1,4'd5,1'b0,32'h0,1'b0,32'h0,1'b0,          1'b0,1'b1,32'h0F0F_0F0F,1'b1,1'b1,32'h1234_5678,4'd9},
    // R8 user read, unlocked
    '{1'b1,1'b0,1'b0,1'b0,4'd5,1'b0,32'h0,1'b0,32'h0,1'b0,          1'b1,1'b0,32'h0F0F_0F0F,1'b0,1'b1,32'h1234_5678,4'd8},
    // R6 crm mismatch write
    '{1'b1,1'b1,1'b1,1'b0,4'd4,1'b0,32'h0,1'b0,32'h0,1'b0,          1'b0,1'b0,32'h0F0F_0F0F,1'b0,1'b1,32'h1234_5678,4'd6},
    // R6 op1 mismatch, locked user: no trap
    '{1'b1,1'b0,1'b0,1'b1,4'd5,1'b1,32'h0,1'b0,32'h0,1'b0,          1'b0,1'b0,32'h0F0F_0F0F,1'b0,1'b1,32'h1234_5678,4'd6},
    // R10 core write with debugger read
    '{1'b1,1'b1,1'b1,1'b0,4'd5,1'b0,32'h8000_0001,1'b0,32'h0,1'b1,  1'b1,1'b0,32'h0F0F_0F0F,1'b0,1'b1,32'h8000_0001,4'd10},
    // R10 debugger write with core read
    '{1'b1,1'b0,1'b1,1'b0,4'd5,1'b0,32'h0,1'b1,32'h7E57_0000,1'b0,  1'b1,1'b0,32'h0F0F_0F0F,1'b1,1'b1,32'h8000_0001,4'd10},
    // R11 all ones inbound
    '{1'b0,1'b0,1'b0,1'b0,4'd5,1'b0,32'h0,1'b1,32'hFFFF_FFFF,1'b0,  1'b0,1'b0,32'h7E57_0000,1'b1,1'b1,32'h8000_0001,4'd11},
    // R11 all ones outbound, read back inbound
    '{1'b1,1'b1,1'b0,1'b0,4'd5,1'b0,32'hFFFF_FFFF,1'b0,32'h0,1'b0,  1'b1,1'b0,32'hFFFF_FFFF,1'b1,1'b1,32'hFFFF_FFFF,4'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, priv = 1'b0, lock = 1'b0;
  logic [2:0]  op1 = '0, op2 = '0;
  logic [3:0]  crn = '0, crm = 4'd5;
  logic [31:0] cwd = '0, dwd = '0;
  logic        dw = 1'b0, dr = 1'b0;
  logic [31:0] crd, drd;
  logic        ack, undef, rxf, txf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dbg_xfer_mbox u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .core_req_i(req), .core_wr_i(wr), .core_priv_i(priv), .user_lock_i(lock),
    .core_op1_i(op1), .core_crn_i(crn), .core_crm_i(crm), .core_op2_i(op2),
    .core_wdata_i(cwd), .core_rdata_o(crd), .core_ack_o(ack), .core_undef_o(undef),
    .dbg_wr_i(dw), .dbg_wdata_i(dwd), .dbg_rd_i(dr), .dbg_rdata_o(drd),
    .rx_full_o(rxf), .tx_full_o(txf)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    req = 0; wr = 0; priv = 0; lock = 0; op1 = 0; crn = 0; crm = 4'd5; op2 = 0;
    cwd = 0; dw = 0; dwd = 0; dr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1", "rx_full", 32'(rxf), 32'h0);
    chk("R1", "tx_full", 32'(txf), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 after release
    chk("R1", "core_rdata", crd, 32'h0);
    chk("R1", "dbg_rdata", drd, 32'h0);
    chk("R1", "flags", {30'h0, rxf, txf}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      tag = $sformatf("R%0d", VECS[i].rq);
      req = VECS[i].req; wr = VECS[i].wr; priv = VECS[i].priv; lock = VECS[i].lock;
      crm = VECS[i].crm; op1 = VECS[i].bad_op1 ? 3'd1 : 3'd0;
      cwd = VECS[i].cwd; dw = VECS[i].dw; dwd = VECS[i].dwd; dr = VECS[i].dr;
      #1;
      chk(tag, "ack", 32'(ack), 32'(VECS[i].e_ack));
      chk(tag, "undef", 32'(undef), 32'(VECS[i].e_undef));
      chk(tag, "core_rdata", crd, VECS[i].e_crd);
      @(posedge clk); #1;
      chk(tag, "rx_full", 32'(rxf), 32'(VECS[i].e_rxf));
      chk(tag, "tx_full", 32'(txf), 32'(VECS[i].e_txf));
      chk(tag, "dbg_rdata", drd, VECS[i].e_drd);
      idle();
    end

    // R9 undef is one cycle: gone once the request drops
    @(negedge clk);
    req = 1; wr = 0; lock = 1;
    #1 chk("R9", "undef pulse", 32'(undef), 32'h1);
    @(negedge clk); idle();
    #1 chk("R9", "undef after drop", 32'(undef), 32'h0);

    // R1 reset mid-run clears full state
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1", "rx_full reset", 32'(rxf), 32'h0);
    chk("R1", "tx_full reset", 32'(txf), 32'h0);
    chk("R1", "core_rdata reset", crd, 32'h0);
    chk("R1", "dbg_rdata reset", drd, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule